// File: doc/BRIEF.md
# I2C Wiper Register Bank Target

This block is an I2C target that holds a bank of four byte-wide wiper settings, each one picking one of 256 tap positions on an external resistor ladder. The block runs on a system clock that is much faster than the bus. It oversamples SCL and SDA through two-flop synchronisers, pulls SDA low through an open-drain enable, and presents every wiper value in parallel on a flat output bus.

A controller sets a wiper with a single transaction: START, an identification byte with R/W low, a byte that selects the register, one data byte, then STOP. To read, the controller sends the identification byte and the register byte, issues a repeated START, and sends the identification byte again with R/W high. The target then returns register contents from a pointer that steps by one per byte and wraps from the last register back to register 0. It keeps sending for as long as the controller acknowledges.

The target's 7-bit address is a fixed five-bit prefix set by a parameter, followed by two strap pins. The strap pins are captured at each START and must stay stable for the whole transaction.

Top module: `i2c_wiper_bank`

## Requirements
- R1: After reset every wiper output equals the parameter `RST_TAP` and `sda_oe` is 0 (SDA released).
- R2: An identification byte whose bits [7:3] equal `DEV_ID_HI` and whose bits [2:1] equal `strap_a[1:0]` is acknowledged by pulling SDA low in the ninth clock. Bit 0 is R/W, with 0 meaning write and 1 meaning read.
- R3: An identification byte with any other address is not acknowledged. Every byte that follows it up to the next START or STOP is also not acknowledged and changes no wiper.
- R4: In a write, the register byte and the first data byte are acknowledged. Bits [1:0] of the register byte select the wiper and its upper bits are ignored. The data byte is written to that wiper alone, at the falling SCL edge that starts its acknowledge clock.
- R5: Any further data byte in the same write, before STOP, is not acknowledged and changes no wiper.
- R6: After a repeated START and a matching identification byte with R/W = 1, the target acknowledges and then sends the selected wiper MSB first, one bit per SCL clock.
- R7: Each byte the target sends advances the pointer by one. After wiper 3 the next byte comes from wiper 0, and sending goes on for as long as the controller acknowledges.
- R8: A controller NACK after a data byte ends the output. SDA stays released through any further clocks until the next START or STOP.
- R9: `sda_oe` changes only in the cycle after a synchronised SCL falling edge, a START or a STOP. START and STOP always release SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (resolved wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a | input | 2 | Address strap pins, low two bits of the 7-bit address |
| wipers_o | output | NUM_WIPERS*8 | Wiper values; wiper i in bits [8i+7:8i] |

## Verification
The bench builds the block with a non-default address prefix of 5'b10011 and a reset tap of 8'h3C. This shows that both the identity match and the reset value follow their parameters and are not fixed constants. The bank stays at four wipers, so reads of up to six bytes from random start pointers cross the wrap from wiper 3 to wiper 0 many times. Random strap values change between transactions, so the match is checked against each strap setting. A wrong strap is used to drive the mismatch path.

// File: rtl/wiper_pkg.sv
// Shared definitions for the wiper register bank.
// Assumes: bus bytes are 8 bits wide and are shifted MSB first.
package wiper_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // no transaction in progress
        ST_RX_DEV,  // shifting in the identification byte
        ST_RX_ADDR, // shifting in the register select byte
        ST_RX_DATA, // shifting in write data bytes
        ST_ACK,     // ninth clock of a received byte
        ST_TX,      // shifting out a read data byte
        ST_MACK,    // ninth clock: sampling the controller's ACK
        ST_IGNORE   // not addressed or done, wait for START/STOP
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the system clock domain and detects bus events.
// Assumes: the system clock is at least several times faster than SCL,
// and the bus idles high, so the synchronisers reset to 1.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_q;
    logic         sda_q;
    logic         scl_now;

    // Synchroniser chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_q    <= scl_pipe[TOP];
            sda_q    <= sda_pipe[TOP];
        end
    end

    assign scl_now = scl_pipe[TOP];
    assign sda_s   = sda_pipe[TOP];

    // Edge and START/STOP decode from the synchronised levels.
    always_comb begin
        scl_rise  = scl_now & ~scl_q;
        scl_fall  = ~scl_now & scl_q;
        start_det = scl_now & scl_q & sda_q & ~sda_s;
        stop_det  = scl_now & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/wiper_regfile.sv
// Bank of byte-wide wiper registers with one write port and one read port.
// Assumes: NUM_WIPERS is a power of two, so the index wraps naturally.
module wiper_regfile #(
    parameter int          NUM_WIPERS = 4,
    parameter logic [7:0]  RST_TAP    = 8'h80,
    localparam int         IDX_W      = $clog2(NUM_WIPERS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [7:0]              rd_data,
    output logic [NUM_WIPERS*8-1:0] wipers_flat
);
    logic [7:0] regs [NUM_WIPERS];

    for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
        // One register per wiper, loaded only when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= RST_TAP;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
        assign wipers_flat[g*8 +: 8] = regs[g];
    end

    // Read mux feeding the transmit shifter.
    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/i2c_target_fsm.sv
// Protocol engine: address match, byte shifting, ACK generation, the
// register pointer and read data return.
// Assumes: inputs come from i2c_line_sync. SDA is sampled on SCL rise and
// driven only after SCL fall. START and STOP override every state.
module i2c_target_fsm
    import wiper_pkg::*;
#(
    parameter int         NUM_WIPERS = 4,
    parameter logic [4:0] DEV_ID_HI  = 5'b01010,
    localparam int        IDX_W      = $clog2(NUM_WIPERS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [1:0]       strap_a,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    tgt_state_e state;
    tgt_state_e after_ack;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [6:0] tx;
    logic [1:0] strap_q;
    logic       wrote;
    logic       mack;
    logic       byte_done;
    logic       id_match;

    // Byte boundary and identity compare.
    always_comb begin
        byte_done = scl_fall && (cnt == 4'd8);
        id_match  = (sh[7:1] == {DEV_ID_HI, strap_q});
    end

    // Commit pulse: first data byte of a write, at the start of its ACK.
    assign wr_en   = (state == ST_RX_DATA) && byte_done && !wrote
                     && !start_det && !stop_det;
    assign wr_data = sh;

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            tx        <= '0;
            ptr       <= '0;
            strap_q   <= '0;
            wrote     <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX_DEV;
            cnt     <= '0;
            wrote   <= 1'b0;
            strap_q <= strap_a;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX_DEV, ST_RX_ADDR, ST_RX_DATA: begin
                    if (scl_rise && cnt != 4'd8) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt   <= '0;
                        state <= ST_ACK;
                        if (state == ST_RX_DEV) begin
                            if (!id_match) begin
                                state <= ST_IGNORE;
                            end else begin
                                sda_oe    <= 1'b1;
                                after_ack <= sh[0] ? ST_TX : ST_RX_ADDR;
                            end
                        end else if (state == ST_RX_ADDR) begin
                            sda_oe    <= 1'b1;
                            ptr       <= sh[IDX_W-1:0];
                            wrote     <= 1'b0;
                            after_ack <= ST_RX_DATA;
                        end else begin
                            after_ack <= ST_RX_DATA;
                            if (!wrote) begin
                                sda_oe <= 1'b1;
                                wrote  <= 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise) begin
                        cnt <= 4'd1;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt   <= '0;
                        state <= after_ack;
                        if (after_ack == ST_TX) begin
                            tx     <= rd_data[6:0];
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_MACK;
                    end else if (scl_fall && cnt != 4'd0) begin
                        tx     <= {tx[5:0], 1'b0};
                        sda_oe <= ~tx[6];
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                        cnt  <= 4'd1;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt <= '0;
                        if (mack) begin
                            state  <= ST_TX;
                            tx     <= rd_data[6:0];
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_wiper_bank.sv
// Top level: I2C target holding NUM_WIPERS byte-wide wiper registers.
// Assumes: strap_a is stable from before START until after STOP, and the
// system clock oversamples SCL by a wide margin.
module i2c_wiper_bank #(
    parameter int         NUM_WIPERS = 4,
    parameter logic [4:0] DEV_ID_HI  = 5'b01010,
    parameter logic [7:0] RST_TAP    = 8'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic [1:0]              strap_a,
    output logic [NUM_WIPERS*8-1:0] wipers_o
);
    localparam int IDX_W = $clog2(NUM_WIPERS);

    logic             sda_s_w;
    logic             scl_rise_w;
    logic             scl_fall_w;
    logic             start_w;
    logic             stop_w;
    logic [IDX_W-1:0] ptr_w;
    logic             wr_en_w;
    logic [7:0]       wr_data_w;
    logic [7:0]       rd_data_w;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s_w),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    i2c_target_fsm #(
        .NUM_WIPERS (NUM_WIPERS),
        .DEV_ID_HI  (DEV_ID_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s_w),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .strap_a   (strap_a),
        .rd_data   (rd_data_w),
        .ptr       (ptr_w),
        .wr_en     (wr_en_w),
        .wr_data   (wr_data_w),
        .sda_oe    (sda_oe)
    );

    wiper_regfile #(
        .NUM_WIPERS (NUM_WIPERS),
        .RST_TAP    (RST_TAP)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en_w),
        .wr_idx      (ptr_w),
        .wr_data     (wr_data_w),
        .rd_idx      (ptr_w),
        .rd_data     (rd_data_w),
        .wipers_flat (wipers_o)
    );
endmodule

// File: rtl/i2c_wiper_bank_chk.sv
// Property checker for i2c_wiper_bank, attached with bind below.
// Assumes: internal event strobes are brought out through the bind port list.
module i2c_wiper_bank_chk #(
    parameter int NUM_WIPERS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sda_oe,
    input logic [NUM_WIPERS*8-1:0] wipers,
    input logic                    scl_fall,
    input logic                    start_det,
    input logic                    stop_det,
    input logic                    wr_en
);
    logic [NUM_WIPERS*8-1:0] prev_q;
    logic [NUM_WIPERS-1:0]   chg;

    // History copy of the wiper bus for per-cycle change detection.
    always_ff @(posedge clk) prev_q <= wipers;

    for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_chg
        assign chg[g] = (wipers[g*8 +: 8] != prev_q[g*8 +: 8]);
    end

    assert_oe_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    assert_wiper_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wipers) |-> $past(wr_en));

    assert_single_wiper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    assert_commit_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);

    assert_commit_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sda_oe);
endmodule

bind i2c_wiper_bank i2c_wiper_bank_chk #(.NUM_WIPERS(NUM_WIPERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .wipers    (wipers_o),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w),
    .wr_en     (wr_en_w)
);

// File: tb/tb_i2c_wiper_bank.sv
// Self-checking bench: bus-level controller model, random and directed traffic.
module tb_i2c_wiper_bank;
    localparam int         NW    = 4;
    localparam logic [4:0] DEVHI = 5'b10011;
    localparam logic [7:0] RSTV  = 8'h3C;
    localparam int         Q     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic sda_oe;
    logic [NW*8-1:0] wipers;
    wire  sda_line = m_sda & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [NW];

    always #2.5 clk = ~clk;

    i2c_wiper_bank #(.NUM_WIPERS(NW), .DEV_ID_HI(DEVHI), .RST_TAP(RSTV)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_a(strap), .wipers_o(wipers)
    );

    function automatic logic [7:0] id_byte(input logic [1:0] s, input logic rw);
        return {DEVHI, s, rw};
    endfunction

    function automatic logic [7:0] exp_read(input int p);
        return model[p % NW];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_wipers(input string req);
        for (int i = 0; i < NW; i++) check(req, 32'(wipers[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        m_sda = b; tick(Q); scl = 1'b1; tick(Q);
        r = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], r);
        xfer_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, r);
            d[i] = r;
        end
        xfer_bit(~give_ack, r);
    endtask

    task automatic do_write(input logic [1:0] s, input logic [7:0] addr,
                            input logic [7:0] data, input int extra);
        logic a;
        strap = s; tick(Q);
        bus_start();
        write_byte(id_byte(s, 1'b0), a); check("R2 id ack", 32'(a), 32'd1);
        write_byte(addr, a);             check("R4 addr ack", 32'(a), 32'd1);
        write_byte(data, a);             check("R4 data ack", 32'(a), 32'd1);
        model[addr[1:0]] = data;
        for (int k = 0; k < extra; k++) begin
            write_byte(data ^ 8'hFF, a); check("R5 extra nack", 32'(a), 32'd0);
        end
        bus_stop();
        check_wipers(extra > 0 ? "R5 wipers" : "R4 wipers");
        check("R9 released after stop", 32'(sda_line), 32'd1);
    endtask

    task automatic do_read(input logic [1:0] s, input logic [7:0] addr, input int len);
        logic a;
        logic [7:0] d;
        strap = s; tick(Q);
        bus_start();
        write_byte(id_byte(s, 1'b0), a); check("R2 id ack", 32'(a), 32'd1);
        write_byte(addr, a);             check("R6 addr ack", 32'(a), 32'd1);
        bus_start();
        write_byte(id_byte(s, 1'b1), a); check("R6 read id ack", 32'(a), 32'd1);
        for (int k = 0; k < len; k++) begin
            read_byte(k != len - 1, d);
            check(k == 0 ? "R6 first byte" : "R7 stream byte",
                  32'(d), 32'(exp_read(int'(addr[1:0]) + k)));
        end
        bus_stop();
        check_wipers("R6 read leaves wipers");
    endtask

    // Watchdog: ends a hung run as a counted failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        logic [7:0] tmp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) model[i] = RSTV;
        tick(6);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        check_wipers("R1 reset wipers");
        check("R1 sda released", 32'(sda_oe), 32'd0);

        // Directed write to every wiper; upper address bits set (ignored, R4)
        for (int i = 0; i < NW; i++)
            do_write(2'(i), {6'b101101, 2'(i)}, 8'h11 * 8'(i + 1), 0);

        // R7: wrap from wiper 3 to 0 and onward
        do_read(2'b01, 8'h03, 4);

        // R5: extra data bytes are refused
        do_write(2'b10, 8'h01, 8'hA7, 2);

        // R3: wrong strap bits, then bytes that must be ignored
        strap = 2'b11; tick(Q);
        bus_start();
        write_byte(id_byte(2'b00, 1'b0), a); check("R3 mismatch nack", 32'(a), 32'd0);
        write_byte(8'h02, a);                check("R3 addr ignored", 32'(a), 32'd0);
        write_byte(8'hEE, a);                check("R3 data ignored", 32'(a), 32'd0);
        bus_stop();
        check_wipers("R3 wipers unchanged");

        // R8: controller NACK ends output; further clocks read released SDA
        strap = 2'b00; tick(Q);
        bus_start();
        write_byte(id_byte(2'b00, 1'b0), a);
        write_byte(8'h02, a);
        bus_start();
        write_byte(id_byte(2'b00, 1'b1), a);
        read_byte(1'b0, d);
        check("R8 last byte", 32'(d), 32'(model[2]));
        read_byte(1'b0, d);
        check("R8 released after nack", 32'(d), 32'hFF);
        check("R8 oe low", 32'(sda_oe), 32'd0);
        bus_stop();

        // Random mix of writes and reads
        for (int it = 0; it < 18; it++) begin
            tmp = 8'($urandom);
            if ($urandom_range(0, 1) == 0)
                do_write(2'($urandom), tmp, 8'($urandom), int'($urandom_range(0, 1)));
            else
                do_read(2'($urandom), tmp, int'($urandom_range(1, 6)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule